// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command interface of a byte-wide flash memory that is erased as a whole and programmed one byte at a time. It runs in one synchronous clock domain. The active-low chip enable, output enable and write enable strobes reach it already sampled. It decides what the data bus shows. It also tells a behavioural memory array when to program a byte, when to erase everything, and which address to read.

While the program supply flag is low, the block only reads. A plain read returns the array byte at the bus address. If the signature flag is asserted, a read returns an identification code instead. While the supply flag is high, bytes written to the command register move a mode machine through set-up and action steps. Program and erase are two-step sequences, and each is closed by a verify command. A stop timer halts any program or erase that runs for too long without a verify. After that halt, the block accepts only a verify or a reset command.

The interface to the array has no back-pressure. The array must act on a request in the cycle that request is raised. The request pins are levels, not handshakes. Reads are combinational: the array returns the byte at `arr_addr` in the same cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case it is 0, and `ce_n`=1 alone always forces it to 0. During a driven cycle, `read_rd` is 1 when array data is shown in a non-verify mode, and `verify_rd` is 1 when array data is shown in a verify mode.
- R2: After reset, and in the cycle after any cycle with `vpp_hi`=0, the block is in read mode, so reads return the array byte at `addr`. While `vpp_hi`=0, command writes have no effect.
- R3: A command write takes the address present in the cycle where `we_n` falls with `ce_n` low. It takes the data present in the cycle where `we_n` rises with `ce_n` still low, and it acts in that cycle.
- R4: In signature mode (command 90h), or whenever `sig_hv`=1, a read returns 20h when `addr[0]`=0 and 07h when `addr[0]`=1.
- R5: Command 40h is a set-up write and leaves the array unchanged. The next write raises `prog_req`, with the address from that write's falling edge and its data. The array stores the old byte AND the new byte.
- R6: Command C0h ends a program and captures the address from its own write. Reads then return the array byte at that captured address, whatever `addr` is, with `verify_rd`=1.
- R7: Command 20h followed by a second 20h raises `erase_req`, and the array sets every byte to FFh. Command 20h followed by any other byte returns to read mode with no erase.
- R8: Command A0h ends an erase and captures its address. Reads then return the array byte at that address with `verify_rd`=1.
- R9: `prog_req` or `erase_req` stays high for exactly `STOP_CYCLES` cycles if no verify or reset write arrives. The block then halts. While running or halted, it accepts only A0h, C0h and FFh, and ignores every other command byte.
- R10: Command FFh followed by any second write returns to read mode.
- R11: While `vcc_ok`=0, command writes are ignored.
- R12: Command 00h, and any byte that is not a defined command code, selects read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Bus address |
| din | input | 8 | Bus write data |
| vpp_hi | input | 1 | Program supply at its high level |
| vcc_ok | input | 1 | Supply above the write lockout level |
| sig_hv | input | 1 | High voltage on the signature pin |
| arr_rdata | input | 8 | Array byte at `arr_addr` |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Drive enable for `dout` (0 means high impedance) |
| arr_addr | output | 17 | Array address for program, verify or read |
| arr_wdata | output | 8 | Program data |
| prog_req | output | 1 | Program operation active |
| erase_req | output | 1 | Chip erase operation active |
| verify_rd | output | 1 | Verify read of the array |
| read_rd | output | 1 | Normal read of the array |

## Verification
The assertions check on every cycle that:
- standby never drives the bus;
- signature reads give only the two codes;
- a low program supply forces read mode;
- an operation begins only straight after its set-up step, and an erase only after a confirming 20h;
- a halt follows only a running operation;
- the stop counter stays in bounds;
- lockout freezes the mode.

Only the bench scenarios can show the data itself: the AND on programming, the all-FFh erase, verify reads at the captured address, the address split between the two write edges, the exact length of a timed-out operation, and the command bytes ignored while halted.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_SIG, ST_ERS_SU, ST_ERS_RUN, ST_ERS_VFY,
    ST_PRG_SU, ST_PRG_RUN, ST_PRG_VFY, ST_RST_SU, ST_HALT
  } fcc_state_e;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_SIG   = 8'h90;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_EVFY  = 8'hA0;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_PVFY  = 8'hC0;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] MFR_CODE  = 8'h20;
  localparam logic [7:0] DEV_CODE  = 8'h07;

  function automatic fcc_state_e decode_cmd(input logic [7:0] c);
    case (c)
      CMD_SIG:   return ST_SIG;
      CMD_ERASE: return ST_ERS_SU;
      CMD_EVFY:  return ST_ERS_VFY;
      CMD_PROG:  return ST_PRG_SU;
      CMD_PVFY:  return ST_PRG_VFY;
      CMD_RESET: return ST_RST_SU;
      default:   return ST_READ;
    endcase
  endfunction
endpackage

// File: rtl/fcc_bus_sampler.sv
module fcc_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic vpp_hi,
  input  logic vcc_ok,
  output logic wr_start,
  output logic wr_commit
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  // falling edge of write enable with chip selected: capture address
  assign wr_start  = !ce_n && we_q && !we_n;
  // rising edge with chip selected: command byte lands, if writes allowed
  assign wr_commit = !ce_n && !we_q && we_n && vpp_hi && vcc_ok;
endmodule

// File: rtl/fcc_stop_timer.sv
module fcc_stop_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
  import fcc_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_hi,
  input  logic          wr_start,
  input  logic          wr_commit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          expire,
  output fcc_state_e    state,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  logic [AW-1:0] bus_addr_q;
  logic          is_vfy, busy_ok;

  assign is_vfy  = (din[7:0] == CMD_EVFY) || (din[7:0] == CMD_PVFY);
  assign busy_ok = is_vfy || (din[7:0] == CMD_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_READ;
      bus_addr_q <= '0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      if (wr_start) bus_addr_q <= addr;
      if (!vpp_hi) begin
        state <= ST_READ;
      end else if (wr_commit) begin
        unique case (state)
          ST_ERS_SU: state <= (din[7:0] == CMD_ERASE) ? ST_ERS_RUN : ST_READ;
          ST_PRG_SU: begin
            state   <= ST_PRG_RUN;
            op_addr <= bus_addr_q;
            op_data <= din;
          end
          ST_RST_SU: state <= ST_READ;
          ST_ERS_RUN, ST_PRG_RUN, ST_HALT: begin
            if (busy_ok) begin
              state <= decode_cmd(din[7:0]);
              if (is_vfy) op_addr <= bus_addr_q;
            end
          end
          default: begin
            state <= decode_cmd(din[7:0]);
            if (is_vfy) op_addr <= bus_addr_q;
          end
        endcase
      end else if (expire) begin
        state <= ST_HALT;
      end
    end
  end

  a_r2_vpp_low_forces_read: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |=> (state == ST_READ));
  a_r5_prog_follows_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRG_RUN && $past(state) != ST_PRG_RUN) |-> ($past(state) == ST_PRG_SU));
  a_r7_erase_needs_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERS_RUN && $past(state) != ST_ERS_RUN)
      |-> ($past(state) == ST_ERS_SU && $past(din[7:0]) == CMD_ERASE));
  a_r9_halt_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && $past(state) != ST_HALT)
      |-> ($past(state) == ST_PRG_RUN || $past(state) == ST_ERS_RUN));
endmodule

// File: rtl/fcc_out_mux.sv
module fcc_out_mux
  import fcc_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          vpp_hi,
  input  logic          sig_hv,
  input  logic [AW-1:0] addr,
  input  fcc_state_e    state,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          prog_req,
  output logic          erase_req,
  output logic          verify_rd,
  output logic          read_rd
);
  logic rd_active, sig_sel, vfy_mode;
  logic [DW-1:0] sig_byte;

  assign rd_active = !ce_n && !oe_n && we_n;
  assign sig_sel   = sig_hv || (vpp_hi && state == ST_SIG);
  assign vfy_mode  = vpp_hi && (state == ST_ERS_VFY || state == ST_PRG_VFY);
  assign sig_byte  = DW'(addr[0] ? DEV_CODE : MFR_CODE);

  assign prog_req  = (state == ST_PRG_RUN);
  assign erase_req = (state == ST_ERS_RUN);
  assign arr_addr  = (prog_req || vfy_mode) ? op_addr : addr;
  assign arr_wdata = op_data;

  always_comb begin
    dout_en   = rd_active;
    dout      = '0;
    verify_rd = 1'b0;
    read_rd   = 1'b0;
    if (rd_active) begin
      if (sig_sel) begin
        dout = sig_byte;
      end else begin
        dout      = arr_rdata;
        verify_rd = vfy_mode;
        read_rd   = !vfy_mode;
      end
    end
  end

  a_r1_strobes_exclusive: assert final (!(verify_rd && read_rd));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int STOP_CYCLES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          vpp_hi,
  input  logic          vcc_ok,
  input  logic          sig_hv,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          prog_req,
  output logic          erase_req,
  output logic          verify_rd,
  output logic          read_rd
);
  logic       wr_start, wr_commit, expire, run;
  fcc_state_e state;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  fcc_bus_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .vpp_hi(vpp_hi), .vcc_ok(vcc_ok),
    .wr_start(wr_start), .wr_commit(wr_commit)
  );

  assign run = (state == ST_PRG_RUN) || (state == ST_ERS_RUN);

  fcc_stop_timer #(.LIMIT(STOP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .expire(expire)
  );

  fcc_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .vpp_hi(vpp_hi),
    .wr_start(wr_start), .wr_commit(wr_commit),
    .addr(addr), .din(din), .expire(expire),
    .state(state), .op_addr(op_addr), .op_data(op_data)
  );

  fcc_out_mux #(.AW(AW), .DW(DW)) u_out (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .vpp_hi(vpp_hi), .sig_hv(sig_hv),
    .addr(addr), .state(state), .op_addr(op_addr), .op_data(op_data),
    .arr_rdata(arr_rdata), .dout(dout), .dout_en(dout_en),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .prog_req(prog_req), .erase_req(erase_req),
    .verify_rd(verify_rd), .read_rd(read_rd)
  );

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  a_r4_signature_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && sig_hv) |-> (dout == DW'(MFR_CODE) || dout == DW'(DEV_CODE)));
  a_r11_lockout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !vcc_ok && !run) |=> $stable(state));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int STOP_N = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic vpp_hi = 1'b0, vcc_ok = 1'b1, sig_hv = 1'b0;
  logic [DW-1:0] arr_rdata, dout, arr_wdata;
  logic [AW-1:0] arr_addr;
  logic dout_en, prog_req, erase_req, verify_rd, read_rd;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .STOP_CYCLES(STOP_N)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .vpp_hi(vpp_hi), .vcc_ok(vcc_ok), .sig_hv(sig_hv),
    .arr_rdata(arr_rdata), .dout(dout), .dout_en(dout_en),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .prog_req(prog_req), .erase_req(erase_req),
    .verify_rd(verify_rd), .read_rd(read_rd)
  );

  function automatic logic [7:0] init_byte(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // behavioural array: program ANDs, erase sets FFh
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
    end else if (erase_req) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    end else if (prog_req) begin
      mem[arr_addr[7:0]] = mem[arr_addr[7:0]] & arr_wdata;
    end
  end
  assign arr_rdata = mem[arr_addr[7:0]];

  // scoreboard queues
  logic [7:0] q_d[$];
  bit q_en[$], q_vr[$], q_rr[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares outputs a quarter period after each falling edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    while (q_d.size() > 0) begin
      automatic logic [7:0] ed = q_d.pop_front();
      automatic bit ee = q_en.pop_front();
      automatic bit ev = q_vr.pop_front();
      automatic bit er = q_rr.pop_front();
      automatic string t = q_tag.pop_front();
      check(dout_en === ee && (!ee || dout === ed) && verify_rd === ev && read_rd === er,
            t, {dout_en, verify_rd, read_rd, dout}, {ee, ev, er, ed});
    end
  end

  task automatic drive_read(input bit c, input bit o, input logic [AW-1:0] a,
                            input logic [7:0] ed, input bit ee, input bit ev,
                            input bit er, input string tag);
    @(negedge clk);
    ce_n = c; oe_n = o; addr = a;
    q_d.push_back(ed); q_en.push_back(ee); q_vr.push_back(ev);
    q_rr.push_back(er); q_tag.push_back(tag);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] ed, input bit vfy, input string tag);
    drive_read(1'b0, 1'b0, a, ed, 1'b1, vfy, !vfy, tag);
  endtask

  task automatic rd_sig(input logic [AW-1:0] a, input logic [7:0] ed, input string tag);
    drive_read(1'b0, 1'b0, a, ed, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic bus_write(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                           input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; addr = a_fall; we_n = 1'b0;
    @(negedge clk);
    addr = a_rise; din = d; we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(dout_en === 1'b0 && prog_req === 1'b0 && erase_req === 1'b0,
          "R2 reset idle", {dout_en, prog_req, erase_req}, 0);

    // R2 read-only: array byte at bus address
    rd(17'h5, init_byte(5), 1'b0, "R2 read-only read");
    // R1 output disable and standby
    drive_read(1'b0, 1'b1, 17'h5, 8'h00, 1'b0, 1'b0, 1'b0, "R1 oe high");
    drive_read(1'b1, 1'b0, 17'h5, 8'h00, 1'b0, 1'b0, 1'b0, "R1 standby");
    // R1 write enable low blocks drive
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 17'h5;
    q_d.push_back(8'h00); q_en.push_back(1'b0); q_vr.push_back(1'b0);
    q_rr.push_back(1'b0); q_tag.push_back("R1 we low");
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

    // R4 high-voltage signature in read-only operation
    sig_hv = 1'b1;
    rd_sig(17'h0, 8'h20, "R4 hv mfr");
    rd_sig(17'h1, 8'h07, "R4 hv dev");
    sig_hv = 1'b0;

    // R2 writes ignored with supply low
    bus_write(17'h0, 17'h0, 8'h90);
    rd(17'h0, init_byte(0), 1'b0, "R2 write ignored vpp low");

    vpp_hi = 1'b1;
    // R4 signature via command
    bus_write(17'h0, 17'h0, 8'h90);
    rd_sig(17'h0, 8'h20, "R4 cmd mfr");
    rd_sig(17'h1, 8'h07, "R4 cmd dev");
    // R12 undefined code selects read
    bus_write(17'h0, 17'h0, 8'h55);
    rd(17'h0, init_byte(0), 1'b0, "R12 unknown code");
    bus_write(17'h0, 17'h0, 8'h90);
    bus_write(17'h0, 17'h0, 8'h00);
    rd(17'h3, init_byte(3), 1'b0, "R12 read cmd");

    // R11 lockout
    vcc_ok = 1'b0;
    bus_write(17'h0, 17'h0, 8'h90);
    rd(17'h0, init_byte(0), 1'b0, "R11 lockout");
    vcc_ok = 1'b1;

    // R5 program set-up leaves array, R3 address split
    bus_write(17'h10, 17'h10, 8'h40);
    rd(17'h10, init_byte(16), 1'b0, "R5 setup no change");
    bus_write(17'h10, 17'h33, 8'h0F);
    check(prog_req === 1'b1 && arr_addr === 17'h10, "R5 prog_req", {prog_req, arr_addr}, {1'b1, 17'h10});
    bus_write(17'h10, 17'h10, 8'hC0);
    rd(17'h77, init_byte(16) & 8'h0F, 1'b1, "R6 program verify");
    bus_write(17'h0, 17'h0, 8'h00);
    rd(17'h33, init_byte(8'h33), 1'b0, "R3 rise address unused");

    // R7 erase abort
    bus_write(17'h0, 17'h0, 8'h20);
    bus_write(17'h0, 17'h0, 8'h33);
    check(erase_req === 1'b0, "R7 abort no erase", erase_req, 0);
    rd(17'h8, init_byte(8), 1'b0, "R7 abort read");

    // R7 erase, R8 erase verify
    bus_write(17'h0, 17'h0, 8'h20);
    bus_write(17'h0, 17'h0, 8'h20);
    check(erase_req === 1'b1, "R7 erase_req", erase_req, 1);
    bus_write(17'h44, 17'h44, 8'hA0);
    rd(17'h05, 8'hFF, 1'b1, "R8 erase verify");

    // R9 stop timer
    bus_write(17'h0, 17'h0, 8'h40);
    bus_write(17'h20, 17'h20, 8'h00);
    begin
      int n = 0;
      while (prog_req === 1'b1 && n < 1000) begin
        n++;
        @(negedge clk);
      end
      check(n == STOP_N, "R9 op length", n, STOP_N);
    end
    bus_write(17'h0, 17'h0, 8'h90);
    rd(17'h0, 8'hFF, 1'b0, "R9 halted ignores 90h");
    bus_write(17'h20, 17'h20, 8'hC0);
    rd(17'h3, 8'h00, 1'b1, "R9 verify after halt");

    // R10 reset
    bus_write(17'h0, 17'h0, 8'hFF);
    bus_write(17'h0, 17'h0, 8'hFF);
    rd(17'h20, 8'h00, 1'b0, "R10 reset to read");

    // R2 supply drop clears command
    bus_write(17'h0, 17'h0, 8'h90);
    @(negedge clk); vpp_hi = 1'b0;
    @(negedge clk); vpp_hi = 1'b1;
    rd(17'h0, 8'hFF, 1'b0, "R2 vpp drop");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule